// File: doc/BRIEF.md
# Stream Byte and Frame Statistics Counter

This block sits beside a byte-lane stream and watches it without taking part in the handshake. Every beat that the source offers and the sink accepts adds its number of valid lanes to a byte total. When that beat also closes a frame, it adds one to a frame total. Both totals stop at their maximum value and do not wrap.

A one-cycle trigger pulse takes a copy of both totals and a tag value, then starts both totals again from zero, all on the same clock edge. The copy goes out as one short frame on a byte-wide output stream, most significant byte first: the tag, then the byte total, then the frame total. Because each record is a single frame, records from several monitors can be merged into one frame further down the line. A trigger that arrives while a record is still being sent is ignored.

Top module: `stream_stat_monitor`

## Requirements
- R1: After reset `rec_valid_o` is low and both totals are zero, so a record triggered before any traffic carries zero byte and frame counts.
- R2: Each accepted beat (`mon_valid_i` and `mon_ready_i` both high) adds to the byte total the number of set bits in `mon_keep_i`.
- R3: Each accepted beat with `mon_last_i` high adds one to the frame total.
- R4: A cycle in which `mon_valid_i` or `mon_ready_i` is low changes neither total, whatever the keep and last inputs carry.
- R5: A record is one frame of TAG_W/8 + 2*CNT_W/8 bytes on `rec_data_o`: the tag, then the byte total, then the frame total, each most significant byte first. `rec_last_o` is high on the final byte only. With default parameters this is 10 bytes.
- R6: On an accepted trigger the record holds the totals as they stood before that cycle. A beat accepted in the trigger cycle is counted into the new interval.
- R7: The tag in a record is the value of `tag_i` in the trigger cycle.
- R8: A trigger while a record is still being sent (up to and including the cycle its last byte is accepted) produces no record and leaves the totals counting on.
- R9: While `rec_valid_o` is high and `rec_ready_i` is low, `rec_valid_o`, `rec_data_o` and `rec_last_o` hold their values.
- R10: Each total saturates at 2^CNT_W-1 and stays there until the next accepted trigger clears it.
- R11: `rec_valid_o` rises in the cycle after an accepted trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_valid_i | input | 1 | Valid of the observed stream |
| mon_ready_i | input | 1 | Ready of the observed stream (observed only) |
| mon_keep_i | input | KEEP_W | Lane-valid mask of the observed stream |
| mon_last_i | input | 1 | End-of-frame flag of the observed stream |
| tag_i | input | TAG_W | Tag placed at the head of the next record |
| trig_i | input | 1 | Snapshot, clear and send request |
| rec_valid_o | output | 1 | Record byte valid |
| rec_ready_i | input | 1 | Record byte accepted by the downstream logic |
| rec_data_o | output | 8 | Record byte |
| rec_last_o | output | 1 | Final byte of the record |

## Verification
Most errors in the totals stay hidden until the next trigger. They then show up as a wrong byte inside a particular field of the record, so every record is compared byte by byte against totals the bench keeps for itself. A serializer state that is off by one shows up within one record as a misplaced `rec_last_o` or a missing or extra byte. A trigger wrongly accepted while a record is being sent shows up as an extra record, or as a shortened interval in the following record. Saturation is run on a narrow-counter instance, where a counter that wraps shows up as a small value in place of all ones.

// File: rtl/stat_mon_pkg.sv
package stat_mon_pkg;

    // serializer phase
    typedef enum logic {
        SER_IDLE = 1'b0,
        SER_SEND = 1'b1
    } ser_state_e;

    // decoded event of one observed cycle
    typedef struct packed {
        logic take;   // handshake completed
        logic eof;    // handshake completed on a frame end
    } beat_evt_t;

    localparam int unsigned BYTE_W = 8;

    function automatic int unsigned bytes_for(input int unsigned bits);
        return (bits + BYTE_W - 1) / BYTE_W;
    endfunction

endpackage

// File: rtl/stat_lane_count.sv
module stat_lane_count #(
    parameter int unsigned KEEP_W = 4,
    parameter int unsigned INC_W  = $clog2(KEEP_W + 1)
) (
    input  logic                    valid_i,
    input  logic                    ready_i,
    input  logic [KEEP_W-1:0]       keep_i,
    input  logic                    last_i,
    output stat_mon_pkg::beat_evt_t evt_o,
    output logic [INC_W-1:0]        lanes_o
);
    import stat_mon_pkg::*;

    always_comb begin
        evt_o.take = valid_i & ready_i;
        evt_o.eof  = valid_i & ready_i & last_i;
    end

    always_comb begin
        lanes_o = '0;
        if (evt_o.take) begin
            for (int i = 0; i < KEEP_W; i++) begin
                lanes_o = lanes_o + INC_W'(keep_i[i]);
            end
        end
    end

endmodule

// File: rtl/stat_sat_counter.sv
module stat_sat_counter #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned INC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic [INC_W-1:0] inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int unsigned PAD_W = CNT_W + 1 - INC_W;

    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        sum     = (clr_i ? {(CNT_W+1){1'b0}} : {1'b0, cnt_o}) + {{PAD_W{1'b0}}, inc_i};
        cnt_nxt = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '0;
        end else begin
            cnt_o <= cnt_nxt;
        end
    end

    // R10
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> cnt_o >= $past(cnt_o));

endmodule

// File: rtl/stat_serializer.sv
module stat_serializer #(
    parameter int unsigned REC_BYTES = 10,
    parameter int unsigned REC_W     = REC_BYTES * 8,
    parameter int unsigned IDX_W     = (REC_BYTES > 1) ? $clog2(REC_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [REC_W-1:0] rec_i,
    output logic             busy_o,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    output logic [7:0]       out_data_o,
    output logic             out_last_o
);
    import stat_mon_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_BYTES - 1);

    ser_state_e       state;
    logic [REC_W-1:0] shreg;
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SER_IDLE;
            shreg <= '0;
            idx   <= '0;
        end else begin
            case (state)
                SER_IDLE: begin
                    if (load_i) begin
                        shreg <= rec_i;
                        idx   <= '0;
                        state <= SER_SEND;
                    end
                end
                SER_SEND: begin
                    if (out_ready_i) begin
                        if (idx == LAST_IDX) begin
                            state <= SER_IDLE;
                        end else begin
                            shreg <= shreg << 8;
                            idx   <= idx + 1'b1;
                        end
                    end
                end
                default: state <= SER_IDLE;
            endcase
        end
    end

    always_comb begin
        busy_o      = (state == SER_SEND);
        out_valid_o = busy_o;
        out_data_o  = shreg[REC_W-1 -: 8];
        out_last_o  = busy_o && (idx == LAST_IDX);
    end

    // R9
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !out_ready_i) |=>
            (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

    // R5
    frame_closes_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && out_ready_i && out_last_o) |=> !out_valid_o);

endmodule

// File: rtl/stream_stat_monitor.sv
module stream_stat_monitor #(
    parameter int unsigned KEEP_W = 4,
    parameter int unsigned TAG_W  = 16,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mon_valid_i,
    input  logic              mon_ready_i,
    input  logic [KEEP_W-1:0] mon_keep_i,
    input  logic              mon_last_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic              trig_i,
    output logic              rec_valid_o,
    input  logic              rec_ready_i,
    output logic [7:0]        rec_data_o,
    output logic              rec_last_o
);
    import stat_mon_pkg::*;

    localparam int unsigned INC_W     = $clog2(KEEP_W + 1);
    localparam int unsigned REC_BYTES = bytes_for(TAG_W) + 2 * bytes_for(CNT_W);
    localparam int unsigned REC_W     = REC_BYTES * 8;

    beat_evt_t        evt;
    logic [INC_W-1:0] lanes;
    logic [CNT_W-1:0] byte_cnt;
    logic [CNT_W-1:0] frame_cnt;
    logic             busy;
    logic             snap;
    logic [REC_W-1:0] record;

    stat_lane_count #(
        .KEEP_W (KEEP_W),
        .INC_W  (INC_W)
    ) lane_i (
        .valid_i (mon_valid_i),
        .ready_i (mon_ready_i),
        .keep_i  (mon_keep_i),
        .last_i  (mon_last_i),
        .evt_o   (evt),
        .lanes_o (lanes)
    );

    assign snap = trig_i && !busy;

    stat_sat_counter #(
        .CNT_W (CNT_W),
        .INC_W (INC_W)
    ) byte_ctr_i (
        .clk   (clk),
        .rst   (rst),
        .clr_i (snap),
        .inc_i (lanes),
        .cnt_o (byte_cnt)
    );

    stat_sat_counter #(
        .CNT_W (CNT_W),
        .INC_W (1)
    ) frame_ctr_i (
        .clk   (clk),
        .rst   (rst),
        .clr_i (snap),
        .inc_i (evt.eof),
        .cnt_o (frame_cnt)
    );

    assign record = REC_W'({tag_i, byte_cnt, frame_cnt});

    stat_serializer #(
        .REC_BYTES (REC_BYTES)
    ) ser_i (
        .clk         (clk),
        .rst         (rst),
        .load_i      (snap),
        .rec_i       (record),
        .busy_o      (busy),
        .out_valid_o (rec_valid_o),
        .out_ready_i (rec_ready_i),
        .out_data_o  (rec_data_o),
        .out_last_o  (rec_last_o)
    );

    // R11
    start_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_i && !busy) |=> rec_valid_o);

    // R3
    frame_seen_chk: assert property (@(posedge clk) disable iff (rst)
        (mon_valid_i && mon_ready_i && mon_last_i) |=> frame_cnt != '0);

endmodule

// File: tb/stream_stat_monitor_tb_top.sv
module stream_stat_monitor_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    // main instance, default parameters
    logic        mon_valid = 0, mon_ready = 0, mon_last = 0, trig = 0;
    logic [3:0]  mon_keep = 0;
    logic [15:0] tag = 0;
    logic        rec_ready = 1;
    logic        rec_valid, rec_last;
    logic [7:0]  rec_data;

    stream_stat_monitor dut_i (
        .clk(clk), .rst(rst),
        .mon_valid_i(mon_valid), .mon_ready_i(mon_ready),
        .mon_keep_i(mon_keep), .mon_last_i(mon_last),
        .tag_i(tag), .trig_i(trig),
        .rec_valid_o(rec_valid), .rec_ready_i(rec_ready),
        .rec_data_o(rec_data), .rec_last_o(rec_last)
    );

    // narrow instance for saturation
    logic       s_valid = 0, s_last = 0, s_trig = 0;
    logic [3:0] s_keep = 0;
    logic [7:0] s_tag = 8'hA5;
    logic       s_rv, s_rl;
    logic [7:0] s_rd;

    stream_stat_monitor #(.KEEP_W(4), .TAG_W(8), .CNT_W(8)) dut_sat_i (
        .clk(clk), .rst(rst),
        .mon_valid_i(s_valid), .mon_ready_i(1'b1),
        .mon_keep_i(s_keep), .mon_last_i(s_last),
        .tag_i(s_tag), .trig_i(s_trig),
        .rec_valid_o(s_rv), .rec_ready_i(1'b1),
        .rec_data_o(s_rd), .rec_last_o(s_rl)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";
    logic [8:0]  exp_q[$];
    logic [31:0] m_bytes = 0, m_frames = 0;
    logic        ign_trig = 0;
    logic [7:0]  got_d[3];
    logic        got_l[3];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int unsigned ones4(input logic [3:0] k);
        int unsigned n = 0;
        for (int i = 0; i < 4; i++) n += k[i];
        return n;
    endfunction

    task automatic push_rec(input logic [15:0] t, input logic [31:0] b, input logic [31:0] f);
        logic [79:0] r;
        r = {t, b, f};
        for (int i = 0; i < 10; i++) exp_q.push_back({(i == 9), r[79 - 8*i -: 8]});
    endtask

    // drive one cycle of stimulus and advance the model
    task automatic cyc(input logic v, input logic r, input logic [3:0] k,
                       input logic l, input logic tr);
        mon_valid = v; mon_ready = r; mon_keep = k; mon_last = l; trig = tr;
        if (tr && !ign_trig) begin
            push_rec(tag, m_bytes, m_frames);
            m_bytes = 0; m_frames = 0;
        end
        if (v && r) begin
            m_bytes  += ones4(k);
            m_frames += l;
        end
        @(posedge clk); #2;
        mon_valid = 0; mon_ready = 0; mon_keep = 0; mon_last = 0; trig = 0;
    endtask

    task automatic drain();
        for (int g = 0; g < 200; g++) begin
            if (exp_q.size() == 0 && !rec_valid) break;
            @(negedge clk);
        end
        check(exp_q.size() == 0, cur_req, "record bytes missing", exp_q.size(), 0);
        @(posedge clk); #2;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rec_valid && rec_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, cur_req, "unexpected record byte", {23'd0, rec_last, rec_data}, 0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check({rec_last, rec_data} == e, cur_req, "record byte/last",
                      {23'd0, rec_last, rec_data}, {23'd0, e});
            end
        end
    end

    initial begin
        #(8 * 150000);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst = 0;
        @(negedge clk);
        // R1
        check(rec_valid == 1'b0, "R1", "rec_valid after reset", rec_valid, 0);
        @(posedge clk); #2;

        // R1 / R11: record before any traffic, valid one cycle after trigger
        cur_req = "R1";
        tag = 16'h1234;
        cyc(0, 0, 4'h0, 0, 1);
        check(rec_valid == 1'b1, "R11", "rec_valid after trigger", rec_valid, 1);
        drain();

        // R2 / R3: keep patterns and frame ends
        cur_req = "R2 R3";
        tag = 16'hBEEF;
        cyc(1, 1, 4'b1111, 0, 0);
        cyc(1, 1, 4'b0111, 0, 0);
        cyc(1, 1, 4'b0001, 1, 0);
        cyc(1, 1, 4'b1010, 1, 0);
        cyc(1, 1, 4'b0000, 1, 0);
        // R4: no handshake, nothing counted
        cyc(1, 0, 4'b1111, 1, 0);
        cyc(0, 1, 4'b1111, 1, 0);
        cyc(0, 0, 4'b1111, 1, 0);
        cyc(0, 0, 4'h0, 0, 1);
        drain();

        cur_req = "R4";
        cyc(1, 0, 4'b1111, 1, 0);
        cyc(0, 1, 4'b0011, 1, 0);
        cyc(0, 0, 4'h0, 0, 1);
        drain();

        // R6: beat in trigger cycle belongs to the next interval
        cur_req = "R6";
        cyc(1, 1, 4'b0011, 0, 0);
        cyc(1, 1, 4'b1111, 1, 1);
        drain();
        cyc(0, 0, 4'h0, 0, 1);
        drain();

        // R7: tag sampled in the trigger cycle
        cur_req = "R7";
        tag = 16'hC0DE;
        cyc(1, 1, 4'b0101, 1, 1);
        tag = 16'hFFFF;
        drain();

        // R9 / R8: stall the output, retrigger while busy
        cur_req = "R9";
        rec_ready = 0;
        tag = 16'h5A3C;
        cyc(1, 1, 4'b1111, 0, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(rec_valid && rec_data == 8'h5A && !rec_last, "R9",
                  "stalled output hold", {22'd0, rec_valid, rec_last, rec_data}, {22'd0, 2'b10, 8'h5A});
        end
        @(posedge clk); #2;
        cur_req = "R8";
        ign_trig = 1;
        tag = 16'h0BAD;
        cyc(1, 1, 4'b1111, 1, 1);
        cyc(1, 1, 4'b0110, 0, 1);
        ign_trig = 0;
        for (int i = 0; i < 12; i++) begin
            rec_ready = i[0];
            @(posedge clk); #2;
        end
        rec_ready = 1;
        drain();
        tag = 16'h7777;
        cyc(0, 0, 4'h0, 0, 1);
        drain();

        // R8: trigger in the cycle the last byte is accepted is ignored
        cur_req = "R8";
        tag = 16'h1111;
        cyc(1, 1, 4'b0001, 1, 1);
        repeat (9) begin @(posedge clk); #2; end
        ign_trig = 1;
        cyc(1, 1, 4'b0011, 0, 1);
        ign_trig = 0;
        @(negedge clk);
        check(rec_valid == 1'b0, "R8", "no record from busy trigger", rec_valid, 0);
        @(posedge clk); #2;
        drain();
        cyc(0, 0, 4'h0, 0, 1);
        drain();

        // R10: saturation on the narrow instance
        s_valid = 1; s_keep = 4'hF; s_last = 1;
        repeat (300) @(posedge clk);
        #2 s_valid = 0; s_last = 0; s_trig = 1;
        @(posedge clk); #2 s_trig = 0;
        begin
            int n = 0;
            for (int g = 0; g < 20 && n < 3; g++) begin
                @(negedge clk);
                if (s_rv) begin got_d[n] = s_rd; got_l[n] = s_rl; n++; end
            end
        end
        check(got_d[0] == 8'hA5 && !got_l[0], "R10", "narrow tag byte", got_d[0], 8'hA5);
        check(got_d[1] == 8'hFF, "R10", "saturated byte total", got_d[1], 8'hFF);
        check(got_d[2] == 8'hFF && got_l[2], "R10", "saturated frame total", got_d[2], 8'hFF);
        @(posedge clk); #2;
        s_valid = 1; s_keep = 4'b0011;
        @(posedge clk); #2 s_valid = 0; s_trig = 1;
        @(posedge clk); #2 s_trig = 0;
        begin
            int n = 0;
            for (int g = 0; g < 20 && n < 3; g++) begin
                @(negedge clk);
                if (s_rv) begin got_d[n] = s_rd; got_l[n] = s_rl; n++; end
            end
        end
        check(got_d[1] == 8'h02, "R10", "byte total after clear", got_d[1], 8'h02);
        check(got_d[2] == 8'h00 && got_l[2], "R10", "frame total after clear", got_d[2], 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule